// File: doc/BRIEF.md
# Byte-Lane Dual-Source Register File

This block is a small word-addressed store shared by a peripheral controller's programmable registers and its transfer staging buffer. The lower eight words act as a staging buffer for direct-memory-access data, so that a few bus cycles granted late do not drop words. The upper eight words hold the controller's registers, selected by the bus slave logic through a three-bit register index.

The file address comes from one of two places. When the bus-side select is high, the bus register index drives the address and the internal address file is locked out. Otherwise a four-entry table of four-bit addresses, loaded by the microsequencer, supplies the address. That table can be loaded at one entry and read at another in the same cycle. The word to be written is either the processor result bus or the received bus data. On the bus-data path, either or both of two protected bits can be taken back from the word already stored. Each byte lane is written and read under its own enable.

Top module: `rf_dual_src_file`

## Requirements
- R1: After the active-low reset, every word of the file and every entry of the address file reads as zero.
- R2: While bus_sel_i is 1, the file address is {1'b1, bus_reg_idx_i} (words 8 to 15), whatever the address file holds.
- R3: While bus_sel_i is 0, the file address is the address-file entry chosen by af_rd_idx_i.
- R4: A load of the address file (af_wr_en_i) takes effect on the rising clock edge. In the same cycle, another entry can be read and returns its stored value, and the loaded entry still shows its old value.
- R5: src_sel_i = 0 writes result_i and src_sel_i = 1 writes bus_data_i.
- R6: With src_sel_i = 1, restore_i[0] keeps stored bit 8 and restore_i[1] keeps stored bit 15 instead of taking them from bus_data_i. With src_sel_i = 0, restore_i has no effect.
- R7: wr_lane_i[0] writes bits 7:0 and wr_lane_i[1] writes bits 15:8. A byte that is not enabled keeps its stored value.
- R8: rd_lane_i[0] gates bits 7:0 and rd_lane_i[1] gates bits 15:8 of rd_data_o. A lane that is not enabled reads as zero.
- R9: Writes to the file take effect on the rising clock edge. rd_data_o follows the selected address combinationally.
- R10: Buffer words 0 to 7 are reachable only through the address file. A bus-side write never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus slave owns the file address |
| bus_reg_idx_i | input | 3 | Register index from the bus address |
| af_wr_en_i | input | 1 | Load one address-file entry |
| af_wr_idx_i | input | 2 | Address-file entry to load |
| af_wr_data_i | input | 4 | Address value to load |
| af_rd_idx_i | input | 2 | Address-file entry driving the file address |
| src_sel_i | input | 1 | Write source: 0 result bus, 1 bus data |
| result_i | input | 16 | Processor result bus |
| bus_data_i | input | 16 | Received bus data |
| restore_i | input | 2 | Keep stored bit 8 ([0]) or bit 15 ([1]) on the bus-data path |
| wr_lane_i | input | 2 | Byte-lane write enables |
| rd_lane_i | input | 2 | Byte-lane read enables |
| addr_o | output | 4 | Effective file address |
| rd_data_o | output | 16 | Read data, gated per lane |

## Verification
A wrong entry in the address file shows on addr_o, with no delay, as soon as that entry is selected. A corrupted word in the file shows on rd_data_o as soon as its address is driven and its lane is enabled. A faulty lane enable or a wrong restore bit leaves one byte or one bit altered. That change appears on the first read after the write edge, so the bench always reads the whole word back one cycle after each write.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    SRC_RESULT = 1'b0,
    SRC_BUS    = 1'b1
  } wsrc_e;
endpackage

// File: rtl/rf_addr_file.sv
module rf_addr_file #(
  parameter int AF_DEPTH = 4,
  parameter int ADDR_W   = 4,
  localparam int IDX_W   = $clog2(AF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] entry_q [AF_DEPTH];

  for (genvar e = 0; e < AF_DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[e] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
        entry_q[e] <= wr_data_i;
      end
    end
  end

  // read port sees stored value only: no bypass from the write port
  assign rd_data_o = entry_q[rd_idx_i];
endmodule

// File: rtl/rf_addr_sel.sv
module rf_addr_sel #(
  parameter int ADDR_W = 4,
  localparam int REG_W = ADDR_W - 1
) (
  input  logic              bus_sel_i,
  input  logic [REG_W-1:0]  bus_reg_idx_i,
  input  logic [ADDR_W-1:0] af_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] bus_addr;

  // registers live in the upper half of the file
  assign bus_addr = {1'b1, bus_reg_idx_i};

  always_comb begin
    if (bus_sel_i) addr_o = bus_addr;
    else           addr_o = af_addr_i;
  end
endmodule

// File: rtl/rf_wdata_mux.sv
module rf_wdata_mux
  import rf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RESTORE_LO = 8,
  parameter int RESTORE_HI = 15,
  localparam int N_RST     = 2
) (
  input  logic              src_sel_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [DATA_W-1:0] cur_word_i,
  input  logic [N_RST-1:0]  restore_i,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int RST_POS [N_RST] = '{RESTORE_LO, RESTORE_HI};

  logic [DATA_W-1:0] bus_path;

  always_comb begin
    bus_path = bus_data_i;
    for (int k = 0; k < N_RST; k++) begin
      if (restore_i[k]) bus_path[RST_POS[k]] = cur_word_i[RST_POS[k]];
    end
  end

  always_comb begin
    unique case (wsrc_e'(src_sel_i))
      SRC_BUS:    wdata_o = bus_path;
      default:    wdata_o = result_i;
    endcase
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int LANE_W  = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        wr_lane_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       word_o,
  output logic [DEPTH*DATA_W-1:0] mem_flat_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) lane_q[w] <= '0;
      end else if (wr_lane_i[l]) begin
        lane_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign word_o[l*LANE_W +: LANE_W] = lane_q[addr_i];

    for (genvar w = 0; w < DEPTH; w++) begin : g_flat
      assign mem_flat_o[w*DATA_W + l*LANE_W +: LANE_W] = lane_q[w];
    end
  end
endmodule

// File: rtl/rf_dual_src_file.sv
module rf_dual_src_file #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 16,
  parameter int LANE_W     = 8,
  parameter int AF_DEPTH   = 4,
  parameter int RESTORE_LO = 8,
  parameter int RESTORE_HI = 15
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bus_sel_i,
  input  logic [$clog2(DEPTH)-2:0]      bus_reg_idx_i,
  input  logic                          af_wr_en_i,
  input  logic [$clog2(AF_DEPTH)-1:0]   af_wr_idx_i,
  input  logic [$clog2(DEPTH)-1:0]      af_wr_data_i,
  input  logic [$clog2(AF_DEPTH)-1:0]   af_rd_idx_i,
  input  logic                          src_sel_i,
  input  logic [DATA_W-1:0]             result_i,
  input  logic [DATA_W-1:0]             bus_data_i,
  input  logic [1:0]                    restore_i,
  input  logic [DATA_W/LANE_W-1:0]      wr_lane_i,
  input  logic [DATA_W/LANE_W-1:0]      rd_lane_i,
  output logic [$clog2(DEPTH)-1:0]      addr_o,
  output logic [DATA_W-1:0]             rd_data_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LANES  = DATA_W / LANE_W;

  logic [ADDR_W-1:0]       af_addr;
  logic [ADDR_W-1:0]       addr;
  logic [DATA_W-1:0]       cur_word;
  logic [DATA_W-1:0]       wdata;
  logic [DEPTH*DATA_W-1:0] mem_flat;

  rf_addr_file #(.AF_DEPTH(AF_DEPTH), .ADDR_W(ADDR_W)) i_addr_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (af_wr_en_i),
    .wr_idx_i  (af_wr_idx_i),
    .wr_data_i (af_wr_data_i),
    .rd_idx_i  (af_rd_idx_i),
    .rd_data_o (af_addr)
  );

  rf_addr_sel #(.ADDR_W(ADDR_W)) i_addr_sel (
    .bus_sel_i     (bus_sel_i),
    .bus_reg_idx_i (bus_reg_idx_i),
    .af_addr_i     (af_addr),
    .addr_o        (addr)
  );

  rf_wdata_mux #(
    .DATA_W(DATA_W), .RESTORE_LO(RESTORE_LO), .RESTORE_HI(RESTORE_HI)
  ) i_wdata_mux (
    .src_sel_i  (src_sel_i),
    .result_i   (result_i),
    .bus_data_i (bus_data_i),
    .cur_word_i (cur_word),
    .restore_i  (restore_i),
    .wdata_o    (wdata)
  );

  rf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W)) i_storage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .wr_lane_i  (wr_lane_i),
    .wdata_i    (wdata),
    .word_o     (cur_word),
    .mem_flat_o (mem_flat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_rd_gate
    assign rd_data_o[l*LANE_W +: LANE_W] =
      rd_lane_i[l] ? cur_word[l*LANE_W +: LANE_W] : '0;
  end

  assign addr_o = addr;
endmodule

// File: rtl/rf_dual_src_file_chk.sv
module rf_dual_src_file_chk #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 16,
  parameter int LANE_W     = 8,
  parameter int AF_DEPTH   = 4,
  parameter int RESTORE_LO = 8,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int LANES     = DATA_W / LANE_W,
  localparam int IDX_W     = $clog2(AF_DEPTH)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    bus_sel_i,
  input logic [ADDR_W-2:0]       bus_reg_idx_i,
  input logic                    af_wr_en_i,
  input logic [IDX_W-1:0]        af_wr_idx_i,
  input logic [ADDR_W-1:0]       af_wr_data_i,
  input logic [IDX_W-1:0]        af_rd_idx_i,
  input logic                    src_sel_i,
  input logic [DATA_W-1:0]       result_i,
  input logic [1:0]              restore_i,
  input logic [LANES-1:0]        wr_lane_i,
  input logic [LANES-1:0]        rd_lane_i,
  input logic [ADDR_W-1:0]       addr_o,
  input logic [DATA_W-1:0]       rd_data_o,
  input logic [DATA_W-1:0]       cur_word,
  input logic [DEPTH*DATA_W-1:0] mem_flat
);
  AST_BUS_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_sel_i |-> addr_o == {1'b1, bus_reg_idx_i});  // R2

  AST_AF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    af_wr_en_i |=> (bus_sel_i || af_rd_idx_i != $past(af_wr_idx_i)
                    || addr_o == $past(af_wr_data_i)));  // R4

  AST_RESULT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lane_i == '1 && !src_sel_i) |=>
      mem_flat[$past(addr_o)*DATA_W +: DATA_W] == $past(result_i));  // R5

  AST_RESTORE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i && restore_i[0] && wr_lane_i[RESTORE_LO/LANE_W]) |=>
      mem_flat[$past(addr_o)*DATA_W + RESTORE_LO] == $past(cur_word[RESTORE_LO]));  // R6

  AST_BUS_WRITE_SPARES_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_sel_i |=> mem_flat[DEPTH*DATA_W/2-1:0] == $past(mem_flat[DEPTH*DATA_W/2-1:0]));  // R10

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_lane_i[l] |=> mem_flat[$past(addr_o)*DATA_W + l*LANE_W +: LANE_W]
                        == $past(cur_word[l*LANE_W +: LANE_W]));  // R7

    AST_READ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_lane_i[l] |-> rd_data_o[l*LANE_W +: LANE_W] == '0);  // R8
  end
endmodule

bind rf_dual_src_file rf_dual_src_file_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W),
  .AF_DEPTH(AF_DEPTH), .RESTORE_LO(RESTORE_LO)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_sel_i     (bus_sel_i),
  .bus_reg_idx_i (bus_reg_idx_i),
  .af_wr_en_i    (af_wr_en_i),
  .af_wr_idx_i   (af_wr_idx_i),
  .af_wr_data_i  (af_wr_data_i),
  .af_rd_idx_i   (af_rd_idx_i),
  .src_sel_i     (src_sel_i),
  .result_i      (result_i),
  .restore_i     (restore_i),
  .wr_lane_i     (wr_lane_i),
  .rd_lane_i     (rd_lane_i),
  .addr_o        (addr_o),
  .rd_data_o     (rd_data_o),
  .cur_word      (cur_word),
  .mem_flat      (mem_flat)
);

// File: tb/test_rf_dual_src_file.sv
module test_rf_dual_src_file;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic [2:0]  bus_reg_idx_i = '0;
  logic        af_wr_en_i = 1'b0;
  logic [1:0]  af_wr_idx_i = '0;
  logic [3:0]  af_wr_data_i = '0;
  logic [1:0]  af_rd_idx_i = '0;
  logic        src_sel_i = 1'b0;
  logic [15:0] result_i = '0;
  logic [15:0] bus_data_i = '0;
  logic [1:0]  restore_i = '0;
  logic [1:0]  wr_lane_i = '0;
  logic [1:0]  rd_lane_i = 2'b11;
  logic [3:0]  addr_o;
  logic [15:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rf_dual_src_file i_rf_dual_src_file (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic af_load(input logic [1:0] idx, input logic [3:0] val);
    af_wr_en_i = 1'b1; af_wr_idx_i = idx; af_wr_data_i = val;
    tick();
    af_wr_en_i = 1'b0;
  endtask

  task automatic point_af(input logic [1:0] idx);
    bus_sel_i = 1'b0; af_rd_idx_i = idx; #1;
  endtask

  task automatic point_bus(input logic [2:0] idx);
    bus_sel_i = 1'b1; bus_reg_idx_i = idx; #1;
  endtask

  task automatic wr(input logic [1:0] lanes, input logic src, input logic [15:0] res,
                    input logic [15:0] bd, input logic [1:0] rst);
    wr_lane_i = lanes; src_sel_i = src; result_i = res; bus_data_i = bd; restore_i = rst;
    tick();
    wr_lane_i = '0; restore_i = '0; #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      point_bus(3'(i));
      check("R1 reg word zero", rd_data_o, 16'h0);
      check("R2 bus address", {12'h0, addr_o}, 16'(8 + i));
    end
    for (int e = 0; e < 4; e++) begin
      point_af(2'(e));
      check("R1 af entry zero", {12'h0, addr_o}, 16'h0);
      check("R1 buffer word zero", rd_data_o, 16'h0);
    end
  endtask

  task automatic t_addr_file();
    af_load(2'd1, 4'd9);
    point_af(2'd1);
    check("R3 af entry selects address", {12'h0, addr_o}, 16'd9);
    af_wr_en_i = 1'b1; af_wr_idx_i = 2'd2; af_wr_data_i = 4'd5;
    af_rd_idx_i = 2'd1; #1;
    check("R4 read other entry during load", {12'h0, addr_o}, 16'd9);
    af_rd_idx_i = 2'd2; #1;
    check("R4 loaded entry old before edge", {12'h0, addr_o}, 16'd0);
    tick();
    af_wr_en_i = 1'b0; #1;
    check("R4 loaded entry after edge", {12'h0, addr_o}, 16'd5);
    point_bus(3'd4);
    check("R2 bus overrides address file", {12'h0, addr_o}, 16'd12);
  endtask

  task automatic t_source();
    af_load(2'd0, 4'd3);
    point_af(2'd0);
    wr_lane_i = 2'b11; src_sel_i = 1'b0; result_i = 16'h1234; #1;
    check("R9 no write before edge", rd_data_o, 16'h0000);
    tick();
    wr_lane_i = '0; #1;
    check("R5 result source", rd_data_o, 16'h1234);
    wr(2'b11, 1'b1, 16'h0F0F, 16'hABCD, 2'b00);
    check("R5 bus data source", rd_data_o, 16'hABCD);
  endtask

  task automatic t_lanes();
    point_af(2'd0);
    wr(2'b01, 1'b0, 16'h55AA, 16'h0, 2'b00);
    check("R7 lower lane only", rd_data_o, 16'hABAA);
    wr(2'b10, 1'b0, 16'h1266, 16'h0, 2'b00);
    check("R7 upper lane only", rd_data_o, 16'h12AA);
    wr(2'b00, 1'b0, 16'hFFFF, 16'hFFFF, 2'b00);
    check("R7 no lane no change", rd_data_o, 16'h12AA);
    rd_lane_i = 2'b01; #1;
    check("R8 lower read lane", rd_data_o, 16'h00AA);
    rd_lane_i = 2'b10; #1;
    check("R8 upper read lane", rd_data_o, 16'h1200);
    rd_lane_i = 2'b00; #1;
    check("R8 no read lane", rd_data_o, 16'h0000);
    rd_lane_i = 2'b11; #1;
  endtask

  task automatic t_restore();
    point_af(2'd0);
    wr(2'b11, 1'b0, 16'h8100, 16'h0, 2'b00);
    wr(2'b11, 1'b1, 16'h0, 16'h0000, 2'b11);
    check("R6 both bits restored", rd_data_o, 16'h8100);
    wr(2'b11, 1'b1, 16'h0, 16'h0055, 2'b01);
    check("R6 bit 8 restored only", rd_data_o, 16'h0155);
    wr(2'b11, 1'b1, 16'h0, 16'h8000, 2'b10);
    check("R6 bit 15 restored low", rd_data_o, 16'h0000);
    wr(2'b11, 1'b0, 16'h0000, 16'hFFFF, 2'b11);
    wr(2'b11, 1'b0, 16'h7E7E, 16'hFFFF, 2'b11);
    check("R6 restore ignored on result path", rd_data_o, 16'h7E7E);
  endtask

  task automatic t_buffer();
    for (int w = 0; w < 8; w++) begin
      af_load(2'd3, 4'(w));
      point_af(2'd3);
      wr(2'b11, 1'b0, 16'hB000 + 16'(w), 16'h0, 2'b00);
    end
    af_load(2'd3, 4'd2);
    for (int r = 0; r < 8; r++) begin
      point_bus(3'(r));
      wr(2'b11, 1'b1, 16'h0, 16'hC000 + 16'(r), 2'b00);
    end
    for (int w = 0; w < 8; w++) begin
      af_load(2'd3, 4'(w));
      point_af(2'd3);
      check("R10 buffer word intact", rd_data_o, 16'hB000 + 16'(w));
    end
    for (int r = 0; r < 8; r++) begin
      point_bus(3'(r));
      check("R2 register word via bus", rd_data_o, 16'hC000 + 16'(r));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_addr_file();
    t_source();
    t_lanes();
    t_restore();
    t_buffer();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule